// File: doc/BRIEF.md
# Operate-Group Microinstruction Unit

This unit executes one operate-class instruction word for a small accumulator machine. Each of twelve low bits of the word enables one elementary action on the accumulator (AC) or on the one-bit link (L). These actions clear, complement, increment or rotate AC and L, merge a switch register into AC, test for a skip, or halt. On a start strobe the unit takes the present AC, L, switch value and word. It applies every enabled action in a fixed order and registers the new AC, the new L, a skip request and a halt flag.

A surrounding sequencer owns fetch, the program counter and memory. It pulses the start input with the current AC and L on the inputs. One cycle later it reads the new values, together with a one-cycle completion pulse. It advances the program counter by one more when the skip output is high. Once an enabled halt has been executed, the unit stays halted and ignores all further start strobes until reset.

Top module: `opr_micro_unit`

## Requirements
- R1: After synchronous active-low reset, the AC output, L output, skip, halt and completion outputs are all zero.
- R2: Word bit 0 clears AC and word bit 1 clears L, before any other action is applied.
- R3: Word bit 2 inverts every AC bit and word bit 3 inverts L. Both apply after the clears, so bits 0 and 2 together give all ones.
- R4: Word bit 4 adds one to AC after the complement step. A carry out of the AC's top bit inverts L.
- R5: Word bit 5 rotates the 17-bit value {L, AC} left by one, so L takes AC's top bit and AC bit 0 takes the old L. Word bit 6 rotates it right by one, so L takes AC bit 0 and AC's top bit takes the old L. Both rotates apply after the increment.
- R6: When word bits 5 and 6 are both set, neither rotate is applied.
- R7: Word bit 10 ORs the switch input into AC, after the rotate step.
- R8: The skip output is high when at least one of these holds on the final AC and L: bit 7 is set and AC's top bit is one; bit 8 is set and AC is zero; bit 9 is set and L is one.
- R9: Word bit 11 sets the halt output after the word's other actions are applied. Halt stays set until reset, and while it is set a start strobe changes no output and gives no completion pulse.
- R10: Word bits 12 and above have no effect on any output.
- R11: The outputs update on the clock edge that samples start high, with completion high for exactly the following cycle. Without start, AC, L and skip hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Execute the word on this edge |
| word_i | input | WORD_W (16) | Instruction word, low 12 bits decoded |
| ac_i | input | DATA_W (16) | Current accumulator |
| link_i | input | 1 | Current link bit |
| switch_i | input | DATA_W (16) | Switch register value |
| ac_o | output | DATA_W (16) | Registered new accumulator |
| link_o | output | 1 | Registered new link bit |
| skip_o | output | 1 | Request to advance the program counter by one extra |
| halt_o | output | 1 | Sticky halt flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The increment and the rotate can both act on the link within one word. The increment's carry inverts L, and the rotate then moves that inverted L into AC. A directed word with both enables set on an all-ones accumulator provokes this, and constrained-random words with every enable mixed reach it many more times. Each result is judged against a bench model that applies the actions one after another in the required order, so a swapped stage order or a carry that skips the link shows up as a wrong AC or L.

// File: rtl/opr_pkg.sv
`timescale 1ns/1ps
// Package: bit positions of the operate word and the decoded control struct.
// Assumes the decoded field occupies the low USED_BITS bits of the word.
package opr_pkg;

    localparam int unsigned BIT_CLA   = 0;
    localparam int unsigned BIT_CLL   = 1;
    localparam int unsigned BIT_CMA   = 2;
    localparam int unsigned BIT_CML   = 3;
    localparam int unsigned BIT_IAC   = 4;
    localparam int unsigned BIT_RAL   = 5;
    localparam int unsigned BIT_RAR   = 6;
    localparam int unsigned BIT_SMA   = 7;
    localparam int unsigned BIT_SZA   = 8;
    localparam int unsigned BIT_SNL   = 9;
    localparam int unsigned BIT_OSR   = 10;
    localparam int unsigned BIT_HLT   = 11;
    localparam int unsigned USED_BITS = 12;

    typedef struct packed {
        logic hlt;
        logic osr;
        logic snl;
        logic sza;
        logic sma;
        logic rar;
        logic ral;
        logic iac;
        logic cml;
        logic cma;
        logic cll;
        logic cla;
    } opr_ctrl_t;

    // Split the decoded field of a word into named enables.
    function automatic opr_ctrl_t decode_word(input logic [USED_BITS-1:0] w);
        opr_ctrl_t c;
        c.cla = w[BIT_CLA];
        c.cll = w[BIT_CLL];
        c.cma = w[BIT_CMA];
        c.cml = w[BIT_CML];
        c.iac = w[BIT_IAC];
        c.ral = w[BIT_RAL];
        c.rar = w[BIT_RAR];
        c.sma = w[BIT_SMA];
        c.sza = w[BIT_SZA];
        c.snl = w[BIT_SNL];
        c.osr = w[BIT_OSR];
        c.hlt = w[BIT_HLT];
        return c;
    endfunction

endpackage

// File: rtl/opr_clear_cmp.sv
`timescale 1ns/1ps
// Stage one and two of the operate sequence: clear, then complement.
// Purely combinational; assumes the enables are already decoded.
module opr_clear_cmp #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              cla_i,
    input  logic              cll_i,
    input  logic              cma_i,
    input  logic              cml_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              link_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o
);

    logic [DATA_W-1:0] ac_clr;
    logic              link_clr;

    // Clear step: zero AC and/or L when enabled.
    always_comb begin
        ac_clr   = cla_i ? '0   : ac_i;
        link_clr = cll_i ? 1'b0 : link_i;
    end

    // Complement step: invert the cleared values when enabled.
    always_comb begin
        ac_o   = cma_i ? ~ac_clr   : ac_clr;
        link_o = cml_i ? ~link_clr : link_clr;
    end

endmodule

// File: rtl/opr_incr.sv
`timescale 1ns/1ps
// Increment stage: adds one to AC; a carry out of the top bit inverts L.
// Purely combinational.
module opr_incr #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              iac_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              link_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o
);

    localparam int unsigned SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] sum;

    // Form the widened sum so the carry is visible.
    always_comb begin
        sum = {1'b0, ac_i} + SUM_W'(1);
    end

    // Select incremented or passed value and fold the carry into L.
    always_comb begin
        if (iac_i) begin
            ac_o   = sum[DATA_W-1:0];
            link_o = link_i ^ sum[DATA_W];
        end else begin
            ac_o   = ac_i;
            link_o = link_i;
        end
    end

endmodule

// File: rtl/opr_rotate.sv
`timescale 1ns/1ps
// Rotate stage over the combined {L, AC} value, one position either way.
// Both directions enabled together cancel out and pass the value unchanged.
module opr_rotate #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              left_i,
    input  logic              right_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              link_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o
);

    localparam int unsigned CW = DATA_W + 1;

    logic [CW-1:0] wide;
    logic [CW-1:0] rot_l;
    logic [CW-1:0] rot_r;
    logic [CW-1:0] result;

    // Build both rotated candidates of the combined value.
    always_comb begin
        wide  = {link_i, ac_i};
        rot_l = {wide[CW-2:0], wide[CW-1]};
        rot_r = {wide[0], wide[CW-1:1]};
    end

    // Pick the candidate from the two direction enables.
    always_comb begin
        unique case ({left_i, right_i})
            2'b10:   result = rot_l;
            2'b01:   result = rot_r;
            default: result = wide;
        endcase
        link_o = result[CW-1];
        ac_o   = result[DATA_W-1:0];
    end

endmodule

// File: rtl/opr_skip_eval.sv
`timescale 1ns/1ps
// Skip evaluation on the final AC and L: any enabled true test requests a skip.
module opr_skip_eval #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              sma_i,
    input  logic              sza_i,
    input  logic              snl_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              link_i,
    output logic              skip_o
);

    logic neg_hit;
    logic zero_hit;
    logic link_hit;

    // Evaluate each test and OR the enabled ones.
    always_comb begin
        neg_hit  = sma_i & ac_i[DATA_W-1];
        zero_hit = sza_i & (ac_i == '0);
        link_hit = snl_i & link_i;
        skip_o   = neg_hit | zero_hit | link_hit;
    end

endmodule

// File: rtl/opr_micro_unit.sv
`timescale 1ns/1ps
// Top: decodes an operate word, chains the action stages in their fixed
// order and registers AC, L, skip, halt and a completion pulse on start.
// Assumes WORD_W >= opr_pkg::USED_BITS; upper word bits are ignored.
module opr_micro_unit #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              link_i,
    input  logic [DATA_W-1:0] switch_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o,
    output logic              skip_o,
    output logic              halt_o,
    output logic              done_o
);

    import opr_pkg::*;

    localparam int unsigned HI_W = WORD_W - USED_BITS;

    opr_ctrl_t         ctrl;
    logic [DATA_W-1:0] ac_s1, ac_s2, ac_s3, ac_fin;
    logic              link_s1, link_s2, link_s3;
    logic              skip_nxt;
    logic              unused_hi;

    logic [DATA_W-1:0] ac_q;
    logic              link_q, skip_q, halt_q, done_q;

    // Decode the low field; upper bits reduced into an intentionally unused net.
    always_comb begin
        ctrl      = decode_word(word_i[USED_BITS-1:0]);
        unused_hi = ^word_i[WORD_W-1:WORD_W-HI_W];
    end

    opr_clear_cmp #(.DATA_W(DATA_W)) u_clear_cmp (
        .cla_i  (ctrl.cla),
        .cll_i  (ctrl.cll),
        .cma_i  (ctrl.cma),
        .cml_i  (ctrl.cml),
        .ac_i   (ac_i),
        .link_i (link_i),
        .ac_o   (ac_s1),
        .link_o (link_s1)
    );

    opr_incr #(.DATA_W(DATA_W)) u_incr (
        .iac_i  (ctrl.iac),
        .ac_i   (ac_s1),
        .link_i (link_s1),
        .ac_o   (ac_s2),
        .link_o (link_s2)
    );

    opr_rotate #(.DATA_W(DATA_W)) u_rotate (
        .left_i  (ctrl.ral),
        .right_i (ctrl.rar),
        .ac_i    (ac_s2),
        .link_i  (link_s2),
        .ac_o    (ac_s3),
        .link_o  (link_s3)
    );

    // Switch merge step, last of the AC actions.
    always_comb begin
        ac_fin = ctrl.osr ? (ac_s3 | switch_i) : ac_s3;
    end

    opr_skip_eval #(.DATA_W(DATA_W)) u_skip (
        .sma_i  (ctrl.sma),
        .sza_i  (ctrl.sza),
        .snl_i  (ctrl.snl),
        .ac_i   (ac_fin),
        .link_i (link_s3),
        .skip_o (skip_nxt)
    );

    // Result register: capture on an accepted start, hold otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ac_q   <= '0;
            link_q <= 1'b0;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !halt_q) begin
                ac_q   <= ac_fin;
                link_q <= link_s3;
                skip_q <= skip_nxt;
                halt_q <= ctrl.hlt;
                done_q <= 1'b1;
            end
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        ac_o   = ac_q;
        link_o = link_q;
        skip_o = skip_q;
        halt_o = halt_q;
        done_o = done_q;
    end

endmodule

// File: rtl/opr_micro_unit_chk.sv
`timescale 1ns/1ps
// Checker for opr_micro_unit, observing its ports only; bound below.
module opr_micro_unit_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WORD_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [WORD_W-1:0] word_i,
    input logic [DATA_W-1:0] ac_o,
    input logic              link_o,
    input logic              skip_o,
    input logic              halt_o,
    input logic              done_o
);

    import opr_pkg::*;

    // R11
    start_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !halt_o) |=> done_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ($stable(ac_o) && $stable(link_o) && $stable(skip_o)));

    // R9
    halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> halt_o);

    // R9
    halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> (!done_o && $stable(ac_o) && $stable(link_o)));

    // R8
    skip_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (skip_o == (($past(word_i[BIT_SMA]) && ac_o[DATA_W-1])
                            || ($past(word_i[BIT_SZA]) && (ac_o == '0))
                            || ($past(word_i[BIT_SNL]) && link_o))));

    // R2
    clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(word_i[BIT_CLA]) && !$past(word_i[BIT_CMA])
         && !$past(word_i[BIT_IAC]) && !$past(word_i[BIT_RAL])
         && !$past(word_i[BIT_RAR]) && !$past(word_i[BIT_OSR])) |-> (ac_o == '0));

endmodule

bind opr_micro_unit opr_micro_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .word_i  (word_i),
    .ac_o    (ac_o),
    .link_o  (link_o),
    .skip_o  (skip_o),
    .halt_o  (halt_o),
    .done_o  (done_o)
);

// File: tb/test_opr_micro_unit.sv
`timescale 1ns/1ps
module test_opr_micro_unit;

    localparam int unsigned DW = 16;
    localparam int unsigned WW = 16;
    localparam int unsigned WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [WW-1:0] word = '0;
    logic [DW-1:0] ac_in = '0;
    logic          l_in = 1'b0;
    logic [DW-1:0] sw = '0;
    logic [DW-1:0] ac_out;
    logic          l_out, skip, halt, done;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    opr_micro_unit #(.DATA_W(DW), .WORD_W(WW)) i_opr_micro_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word),
        .ac_i(ac_in), .link_i(l_in), .switch_i(sw),
        .ac_o(ac_out), .link_o(l_out), .skip_o(skip), .halt_o(halt), .done_o(done)
    );

    // Reference: apply the enabled actions in the required order.
    function automatic logic [DW+1:0] model(input logic [WW-1:0] w, input logic [DW-1:0] a0,
                                            input logic k0, input logic [DW-1:0] s);
        logic [DW-1:0] a;
        logic k, kold, sk;
        a = a0; k = k0;
        if (w[0]) a = '0;
        if (w[1]) k = 1'b0;
        if (w[2]) a = ~a;
        if (w[3]) k = ~k;
        if (w[4]) begin
            if (a == '1) k = ~k;
            a = a + 1'b1;
        end
        if (w[5] && !w[6]) begin
            kold = k; k = a[DW-1]; a = {a[DW-2:0], kold};
        end else if (w[6] && !w[5]) begin
            kold = k; k = a[0]; a = {kold, a[DW-1:1]};
        end
        if (w[10]) a = a | s;
        sk = (w[7] && a[DW-1]) || (w[8] && (a == '0)) || (w[9] && k);
        return {sk, k, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; start = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // Drive one start, sample one negedge later (after the capturing edge).
    task automatic run_op(input logic [WW-1:0] w, input logic [DW-1:0] a,
                          input logic k, input logic [DW-1:0] s);
        @(negedge clk);
        word = w; ac_in = a; l_in = k; sw = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic op_check(input string tag, input logic [WW-1:0] w, input logic [DW-1:0] a,
                            input logic k, input logic [DW-1:0] s,
                            input logic [DW-1:0] ea, input logic ek, input logic es);
        run_op(w, a, k, s);
        check({tag, " ac"},   32'(ac_out), 32'(ea));
        check({tag, " link"}, 32'(l_out),  32'(ek));
        check({tag, " skip"}, 32'(skip),   32'(es));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd24601);
        do_reset();
        // R1 reset state
        check("R1 ac",   32'(ac_out), 0);
        check("R1 link", 32'(l_out),  0);
        check("R1 skip", 32'(skip),   0);
        check("R1 halt", 32'(halt),   0);
        check("R1 done", 32'(done),   0);

        op_check("R2 clear", 16'h0003, 16'h1234, 1'b1, 16'h0, 16'h0000, 1'b0, 1'b0);
        op_check("R3 clear+cmp", 16'h000F, 16'h5A5A, 1'b1, 16'h0, 16'hFFFF, 1'b1, 1'b0);
        op_check("R3 cmp only", 16'h000C, 16'h00FF, 1'b1, 16'h0, 16'hFF00, 1'b0, 1'b0);
        op_check("R4 carry", 16'h0010, 16'hFFFF, 1'b0, 16'h0, 16'h0000, 1'b1, 1'b0);
        op_check("R4 nocarry", 16'h0010, 16'h7FFF, 1'b1, 16'h0, 16'h8000, 1'b1, 1'b0);
        op_check("R4 carry then rotate", 16'h0030, 16'hFFFF, 1'b0, 16'h0, 16'h0001, 1'b0, 1'b0);
        op_check("R5 left", 16'h0020, 16'h8001, 1'b0, 16'h0, 16'h0002, 1'b1, 1'b0);
        op_check("R5 right", 16'h0040, 16'h0001, 1'b1, 16'h0, 16'h8000, 1'b1, 1'b0);
        op_check("R6 both", 16'h0060, 16'h1234, 1'b1, 16'h0, 16'h1234, 1'b1, 1'b0);
        op_check("R7 or after rotate", 16'h0420, 16'h4000, 1'b0, 16'h0001, 16'h8001, 1'b0, 1'b0);
        op_check("R8 neg", 16'h0084, 16'h0000, 1'b0, 16'h0, 16'hFFFF, 1'b0, 1'b1);
        op_check("R8 zero", 16'h0101, 16'h0042, 1'b0, 16'h0, 16'h0000, 1'b0, 1'b1);
        op_check("R8 link", 16'h0208, 16'h0042, 1'b0, 16'h0, 16'h0042, 1'b1, 1'b1);
        op_check("R8 none", 16'h0380, 16'h0001, 1'b0, 16'h0, 16'h0001, 1'b0, 1'b0);
        op_check("R10 upper ignored", 16'hF010, 16'h0005, 1'b0, 16'h0, 16'h0006, 1'b0, 1'b0);
        op_check("R10 upper only", 16'hF000, 16'hABCD, 1'b1, 16'hFFFF, 16'hABCD, 1'b1, 1'b0);

        // R11 completion pulse and hold
        run_op(16'h0010, 16'h0100, 1'b0, 16'h0);
        check("R11 done pulse", 32'(done), 1);
        @(negedge clk);
        check("R11 done drops", 32'(done), 0);
        ac_in = 16'hDEAD; word = 16'h0001;
        @(negedge clk);
        check("R11 hold ac", 32'(ac_out), 32'h0101);

        // Constrained random, halt bit masked off
        for (int i = 0; i < 400; i++) begin
            logic [WW-1:0] w;
            logic [DW-1:0] a, s;
            logic k;
            logic [DW+1:0] e;
            w = WW'($urandom) & 16'hF7FF;
            a = DW'($urandom);
            s = DW'($urandom);
            k = 1'($urandom);
            if (i % 8 == 0) a = '1;
            if (i % 8 == 1) a = '0;
            e = model(w, a, k, s);
            op_check("R5 R8 random", w, a, k, s, e[DW-1:0], e[DW], e[DW+1]);
        end

        // R9 halt is sticky and blocks further starts
        op_check("R9 halt op", 16'h0810, 16'h0007, 1'b0, 16'h0, 16'h0008, 1'b0, 1'b0);
        check("R9 halt set", 32'(halt), 1);
        run_op(16'h0001, 16'h1111, 1'b1, 16'h0);
        check("R9 ignored ac", 32'(ac_out), 32'h0008);
        check("R9 no done", 32'(done), 0);
        check("R9 still halted", 32'(halt), 1);
        do_reset();
        check("R1 halt cleared", 32'(halt), 0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule